// File: doc/BRIEF.md
# Debounced level-interrupt input bank

The bank watches eight external input pins. Each pin is synchronised into the clock domain and then filtered: a clean, stable copy of the pin follows the synchronised value only after that value has stayed unchanged for a programmed number of millisecond ticks. One shared divider derives the ticks from the system clock. Each channel has its own 12-bit hold time. Software reads the filtered levels through a small synchronous register port. A data bit reads as 1 only while the channel is marked as in use.

Each channel can raise a level interrupt. Software picks the active level per channel and then arms the channel. An armed, in-use channel whose filtered level matches the selected level sets a sticky status bit. The same event drops the arm bit, so the channel fires once. The status bit stays set until software writes 1 to it in the clear register. The channel can then fire again only after it is re-armed. An enable register selects which status bits reach the single combined interrupt output.

Top module: `lvlirq_bank`

## Requirements
- R1: After reset, every register reads 0 and irq_o is low. The filtered levels, hold times, arm, enable, polarity and status bits are all 0.
- R2: Offset 0x00 (read-only) returns, in bits 7:0, the filtered level of each channel ANDed with the in-use register at 0x04. A channel whose in-use bit is 0 reads 0 there.
- R3: A filtered level takes the new synchronised pin value only after that value has been held for N consecutive ticks. N is bits 11:0 of the channel's hold word at 0x40 + 4*channel. A tick occurs once every TICK_DIV clocks. A hold time of 0 behaves as 1.
- R4: If the synchronised pin returns to the filtered value before the hold time has elapsed, the count starts again from zero. A train of glitches each shorter than the hold time never changes the filtered level.
- R5: Each hold word stores only bits 11:0. Bits 31:12 are ignored on write and read as 0. Each channel keeps its own word.
- R6: Polarity at 0x14 selects the active level per channel: 1 means high and 0 means low. A channel fires when it is in use, armed (arm register 0x28), and its filtered level equals its polarity bit. Otherwise its status and arm bits are left unchanged.
- R7: When a channel fires, its raw status bit at 0x1C becomes 1 one clock later and its arm bit is cleared by hardware. The status bit stays 1 after the level goes away.
- R8: Writing to 0x24 clears each raw status bit whose written bit is 1. Bits written as 0 have no effect, and 0x24 reads 0. If a fire happens in the same clock as a clear of that bit, the status bit ends up 1.
- R9: Offset 0x20 reads the raw status ANDed with the enable register at 0x18. irq_o is high exactly when that value is nonzero.
- R10: A write to 0x18 that changes an enable bit from 1 to 0 also clears that channel's arm bit. Other arm bits are unchanged.
- R11: Bits 31:8 of the bit-vector registers are ignored on write and read as 0. Writes to read-only or unmapped offsets (including misaligned ones) have no effect, and reads of unmapped offsets return 0.
- R12: After a fire, clearing the status alone does not let the channel fire again even if the level is still active. It fires again only once it has been re-armed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe, captured on the rising clock edge |
| reg_addr | input | 8 | Byte offset of the register for both write and read |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, valid in the same cycle |
| pin_in | input | 8 | Asynchronous external inputs, one per channel |
| irq_o | output | 1 | Combined interrupt: OR of all enabled status bits |

## Verification
The two functions that can fall in the same clock are a software clear of a status bit and a new hardware fire of that same channel. The bench provokes this with two back-to-back writes. First it arms a channel whose filtered level already matches its polarity while its status is still set. In the very next cycle, the cycle in which the fire is evaluated, it writes the clear. The result is judged by reading the status afterwards: the bit must still be 1 and the arm bit 0. A following clear with no fire pending must then leave the status at 0.

// File: rtl/lvlirq_pkg.sv
package lvlirq_pkg;

    // bank geometry
    localparam int unsigned NCH    = 8;
    localparam int unsigned DBW    = 12;
    localparam int unsigned AW     = 8;
    localparam int unsigned DW     = 32;
    localparam int unsigned STRIDE = 4;

    localparam logic [AW-1:0] CTRL_BASE = 8'h40;

    typedef logic [NCH-1:0] chvec_t;
    typedef logic [DBW-1:0] dbcnt_t;

    // register offsets; software decodes these
    typedef enum logic [AW-1:0] {
        RA_DATA  = 8'h00,
        RA_INUSE = 8'h04,
        RA_POL   = 8'h14,
        RA_IEN   = 8'h18,
        RA_RAW   = 8'h1C,
        RA_MSK   = 8'h20,
        RA_CLR   = 8'h24,
        RA_ARM   = 8'h28
    } reg_off_e;

    // per-channel control and status, one bit per channel in each field
    typedef struct packed {
        chvec_t inuse;
        chvec_t pol;
        chvec_t ien;
        chvec_t arm;
        chvec_t raw;
    } bank_state_t;

    typedef struct packed {
        logic          we;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
    } bus_req_t;

    function automatic logic [AW-1:0] ctrl_addr(input int unsigned ch);
        return CTRL_BASE + AW'(STRIDE * ch);
    endfunction

    function automatic dbcnt_t eff_limit(input dbcnt_t lim);
        return (lim == '0) ? dbcnt_t'(1) : lim;
    endfunction

    function automatic logic [DW-1:0] widen_vec(input chvec_t v);
        return DW'(v);
    endfunction

endpackage

// File: rtl/lvlirq_tick.sv
module lvlirq_tick #(
    parameter int unsigned TICK_DIV = 50000
) (
    input  logic clk,
    input  logic rst,
    output logic tick_o
);

    generate
        if (TICK_DIV <= 1) begin : g_every
            always_ff @(posedge clk) begin
                if (rst) tick_o <= 1'b0;
                else     tick_o <= 1'b1;
            end
        end else begin : g_div
            localparam int unsigned CW = $clog2(TICK_DIV);
            localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);
            logic [CW-1:0] cnt_q;

            always_ff @(posedge clk) begin
                if (rst) begin
                    cnt_q  <= '0;
                    tick_o <= 1'b0;
                end else if (cnt_q == LAST) begin
                    cnt_q  <= '0;
                    tick_o <= 1'b1;
                end else begin
                    cnt_q  <= cnt_q + 1'b1;
                    tick_o <= 1'b0;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/lvlirq_filter.sv
module lvlirq_filter
    import lvlirq_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   tick_i,
    input  logic   pin_i,
    input  dbcnt_t limit_i,
    output logic   level_o
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   sampled;
    logic                   level_q;
    dbcnt_t                 cnt_q;
    logic [DBW:0]           cnt_inc;
    logic                   reached;

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= SYNC_STAGES'({sync_q, pin_i});
    end

    assign sampled = sync_q[SYNC_STAGES-1];
    assign cnt_inc = {1'b0, cnt_q} + 1'b1;
    assign reached = cnt_inc >= {1'b0, eff_limit(limit_i)};

    // count ticks while the sample disagrees; any agreement restarts
    always_ff @(posedge clk) begin
        if (rst) begin
            level_q <= 1'b0;
            cnt_q   <= '0;
        end else if (sampled == level_q) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            if (reached) begin
                level_q <= sampled;
                cnt_q   <= '0;
            end else begin
                cnt_q <= cnt_inc[DBW-1:0];
            end
        end
    end

    assign level_o = level_q;

endmodule

// File: rtl/lvlirq_regfile.sv
module lvlirq_regfile
    import lvlirq_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  bus_req_t               req,
    input  chvec_t                 level_i,
    output logic [DW-1:0]          rdata_o,
    output logic                   irq_o,
    output bank_state_t            st_o,
    output logic [NCH-1:0][DBW-1:0] limit_o
);

    bank_state_t             st_q;
    bank_state_t             st_d;
    logic [NCH-1:0][DBW-1:0] limit_q;
    chvec_t                  wvec;
    chvec_t                  match;
    chvec_t                  fire;
    chvec_t                  clr_bits;
    chvec_t                  drop;
    logic                    hit_inuse, hit_pol, hit_ien, hit_arm, hit_clr;
    logic                    wdata_unused;

    assign wvec      = req.wdata[NCH-1:0];
    assign hit_inuse = req.we && (req.addr == RA_INUSE);
    assign hit_pol   = req.we && (req.addr == RA_POL);
    assign hit_ien   = req.we && (req.addr == RA_IEN);
    assign hit_arm   = req.we && (req.addr == RA_ARM);
    assign hit_clr   = req.we && (req.addr == RA_CLR);

    assign wdata_unused = ^req.wdata[DW-1:DBW];

    always_comb begin
        match    = ~(level_i ^ st_q.pol);
        fire     = st_q.arm & st_q.inuse & match;
        clr_bits = hit_clr ? wvec : '0;
        drop     = hit_ien ? (st_q.ien & ~wvec) : '0;

        st_d = st_q;
        if (hit_inuse) st_d.inuse = wvec;
        if (hit_pol)   st_d.pol   = wvec;
        if (hit_ien)   st_d.ien   = wvec;
        // software arm write wins over the hardware disarm of the same cycle
        st_d.arm = (hit_arm ? wvec : (st_q.arm & ~fire)) & ~drop;
        // a new fire outranks a clear landing in the same cycle
        st_d.raw = (st_q.raw & ~clr_bits) | fire;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            limit_q <= '0;
        end else if (req.we) begin
            for (int ch = 0; ch < NCH; ch++) begin
                if (req.addr == ctrl_addr(ch)) limit_q[ch] <= req.wdata[DBW-1:0];
            end
        end
    end

    always_comb begin
        rdata_o = '0;
        case (req.addr)
            RA_DATA:  rdata_o = widen_vec(level_i & st_q.inuse);
            RA_INUSE: rdata_o = widen_vec(st_q.inuse);
            RA_POL:   rdata_o = widen_vec(st_q.pol);
            RA_IEN:   rdata_o = widen_vec(st_q.ien);
            RA_RAW:   rdata_o = widen_vec(st_q.raw);
            RA_MSK:   rdata_o = widen_vec(st_q.raw & st_q.ien);
            RA_ARM:   rdata_o = widen_vec(st_q.arm);
            default: begin
                for (int ch = 0; ch < NCH; ch++) begin
                    if (req.addr == ctrl_addr(ch)) rdata_o = DW'(limit_q[ch]);
                end
            end
        endcase
    end

    assign irq_o   = |(st_q.raw & st_q.ien);
    assign st_o    = st_q;
    assign limit_o = limit_q;

endmodule

// File: rtl/lvlirq_bank.sv
module lvlirq_bank
    import lvlirq_pkg::*;
#(
    parameter int unsigned TICK_DIV    = 50000,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_we,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic [NCH-1:0] pin_in,
    output logic          irq_o
);

    bus_req_t                req_w;
    logic                    tick_w;
    chvec_t                  level_w;
    bank_state_t             st_w;
    logic [NCH-1:0][DBW-1:0] limit_w;

    assign req_w = '{we: reg_we, addr: reg_addr, wdata: reg_wdata};

    lvlirq_tick #(
        .TICK_DIV (TICK_DIV)
    ) u_tick (
        .clk    (clk),
        .rst    (rst),
        .tick_o (tick_w)
    );

    generate
        for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
            lvlirq_filter #(
                .SYNC_STAGES (SYNC_STAGES)
            ) u_filt (
                .clk     (clk),
                .rst     (rst),
                .tick_i  (tick_w),
                .pin_i   (pin_in[ch]),
                .limit_i (limit_w[ch]),
                .level_o (level_w[ch])
            );
        end
    endgenerate

    lvlirq_regfile u_regs (
        .clk     (clk),
        .rst     (rst),
        .req     (req_w),
        .level_i (level_w),
        .rdata_o (reg_rdata),
        .irq_o   (irq_o),
        .st_o    (st_w),
        .limit_o (limit_w)
    );

endmodule

// File: rtl/lvlirq_bank_chk.sv
module lvlirq_bank_chk
    import lvlirq_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          reg_we,
    input logic [AW-1:0] reg_addr,
    input logic [DW-1:0] reg_wdata,
    input logic [DW-1:0] reg_rdata,
    input logic          irq_o,
    input logic          tick_w,
    input chvec_t        level_w,
    input chvec_t        raw,
    input chvec_t        arm,
    input chvec_t        ien,
    input chvec_t        inuse
);

    // R2: data reads never show a channel that is not in use
    p_data_gated_r2: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == RA_DATA) |-> ((reg_rdata & ~widen_vec(inuse)) == '0));

    // R3: filtered levels move only on a tick
    p_level_on_tick_r3: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((level_w == $past(level_w)) || $past(tick_w)));

    // R6: a status bit rises only for a channel that was armed and in use
    p_rise_needs_arm_r6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (((raw & ~$past(raw)) & ~$past(arm & inuse)) == '0));

    // R7: a fire leaves the channel disarmed unless software rewrote the arm
    p_fire_disarms_r7: assert property (@(posedge clk) disable iff (rst)
        !(reg_we && reg_addr == RA_ARM) |=> (((raw & ~$past(raw)) & arm) == '0));

    // R8: without a clear write no status bit falls
    p_raw_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        !(reg_we && reg_addr == RA_CLR) |=> (($past(raw) & ~raw) == '0));

    // R9: the masked view and the interrupt pin agree
    p_irq_view_r9: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == RA_MSK) |-> (irq_o == (reg_rdata != '0)));

    // R10: dropping an enable bit disarms that channel
    p_drop_disarms_r10: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == RA_IEN) |=>
            ((arm & $past(ien & ~reg_wdata[NCH-1:0])) == '0));

    // R11: upper bits of bit-vector registers read zero
    p_reserved_zero_r11: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == RA_DATA || reg_addr == RA_INUSE || reg_addr == RA_POL ||
         reg_addr == RA_IEN || reg_addr == RA_RAW || reg_addr == RA_MSK ||
         reg_addr == RA_CLR || reg_addr == RA_ARM) |-> (reg_rdata[DW-1:NCH] == '0));

endmodule

bind lvlirq_bank lvlirq_bank_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq_o     (irq_o),
    .tick_w    (tick_w),
    .level_w   (level_w),
    .raw       (st_w.raw),
    .arm       (st_w.arm),
    .ien       (st_w.ien),
    .inuse     (st_w.inuse)
);

// File: tb/lvlirq_bank_test.sv
module lvlirq_bank_test;

    localparam int unsigned DIV = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic [7:0]  pin_in = 8'h00;
    logic        irq_o;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    lvlirq_bank #(.TICK_DIV(DIV), .SYNC_STAGES(2)) uut (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .pin_in    (pin_in),
        .irq_o     (irq_o)
    );

    // {offset, write value, expected readback}
    localparam logic [71:0] VEC_TAB [0:11] = '{
        {8'h04, 32'hFFFF_FF00, 32'h0000_0000},
        {8'h14, 32'h1234_56A5, 32'h0000_00A5},
        {8'h18, 32'h0000_013C, 32'h0000_003C},
        {8'h28, 32'hFFFF_FF81, 32'h0000_0081},
        {8'h40, 32'hFFFF_F005, 32'h0000_0005},
        {8'h5C, 32'h0000_1ABC, 32'h0000_0ABC},
        {8'h60, 32'hFFFF_FFFF, 32'h0000_0000},
        {8'h1C, 32'h0000_00FF, 32'h0000_0000},
        {8'h24, 32'h0000_00FF, 32'h0000_0000},
        {8'h42, 32'h0000_00FF, 32'h0000_0000},
        {8'h00, 32'h0000_00FF, 32'h0000_0000},
        {8'h20, 32'h0000_00FF, 32'h0000_0000}
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_we    = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #2;
        d = reg_rdata;
    endtask

    task automatic do_reset();
        pin_in = 8'h00;
        rst    = 1'b1;
        idle(4);
        rst    = 1'b0;
        idle(1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            total++;
            $display("FAIL watchdog R1 actual=timeout expected=completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        idle(1);
        do_reset();

        // R1: reset state
        rd(8'h00, v); chk("R1", "data", v, 32'h0);
        rd(8'h1C, v); chk("R1", "raw", v, 32'h0);
        rd(8'h28, v); chk("R1", "arm", v, 32'h0);
        rd(8'h40, v); chk("R1", "hold0", v, 32'h0);
        chk("R1", "irq", {31'b0, irq_o}, 32'h0);

        // R5 R11: register write/readback table
        for (int i = 0; i < 12; i++) begin
            wr(VEC_TAB[i][71:64], VEC_TAB[i][63:32]);
            rd(VEC_TAB[i][71:64], v);
            chk("R5 R11", $sformatf("table entry %0d", i), v, VEC_TAB[i][31:0]);
        end

        do_reset();

        // R3 R2: hold 3 ticks on ch0, hold 0 (acts as 1) on ch2, ch1 not in use
        wr(8'h40, 32'd3);
        wr(8'h04, 32'h05);
        pin_in = 8'h07;
        idle(14);
        rd(8'h00, v); chk("R3", "only zero-hold channel moved", v, 32'h04);
        idle(26);
        rd(8'h00, v); chk("R3", "ch0 after full hold", v, 32'h05);
        chk("R2", "ch1 hidden while not in use", v & 32'h02, 32'h0);
        wr(8'h04, 32'h07);
        rd(8'h00, v); chk("R2", "ch1 shown once in use", v, 32'h07);

        // R4: glitch train shorter than the hold time
        for (int k = 0; k < 6; k++) begin
            pin_in[0] = 1'b0;
            idle(12);
            pin_in[0] = 1'b1;
            idle(3);
        end
        rd(8'h00, v); chk("R4", "glitch train filtered", v, 32'h07);
        pin_in[0] = 1'b0;
        pin_in[1] = 1'b0;
        idle(40);
        rd(8'h00, v); chk("R4", "held change accepted", v, 32'h04);

        // R6 R7 R9: ch1 active high; filtered ch1 is now 0, drive it high again
        pin_in[1] = 1'b1;
        idle(40);
        wr(8'h14, 32'h02);
        wr(8'h18, 32'h02);
        wr(8'h28, 32'h02);
        idle(2);
        rd(8'h1C, v); chk("R6", "high-level fire", v, 32'h02);
        rd(8'h28, v); chk("R7", "arm dropped by fire", v, 32'h00);
        rd(8'h20, v); chk("R9", "masked status", v, 32'h02);
        chk("R9", "irq high", {31'b0, irq_o}, 32'h1);

        pin_in[1] = 1'b0;
        idle(40);
        rd(8'h1C, v); chk("R7", "status sticky after level gone", v, 32'h02);

        // R8: clear with zero bits, then the real clear
        wr(8'h24, 32'h01);
        rd(8'h1C, v); chk("R8", "zero bits leave status", v, 32'h02);
        wr(8'h24, 32'h02);
        rd(8'h1C, v); chk("R8", "cleared", v, 32'h00);
        chk("R9", "irq low after clear", {31'b0, irq_o}, 32'h0);

        // R6 R9: ch0 active low, not enabled
        wr(8'h28, 32'h01);
        idle(2);
        rd(8'h1C, v); chk("R6", "low-level fire", v, 32'h01);
        rd(8'h20, v); chk("R9", "masked hides disabled", v, 32'h00);
        chk("R9", "irq stays low", {31'b0, irq_o}, 32'h0);

        // R12: clear alone does not re-fire, re-arm does
        wr(8'h24, 32'h01);
        idle(5);
        rd(8'h1C, v); chk("R12", "no refire without arm", v, 32'h00);
        wr(8'h28, 32'h01);
        idle(2);
        rd(8'h1C, v); chk("R12", "refire after re-arm", v, 32'h01);

        // R8: fire and clear of the same bit in one cycle
        wr(8'h28, 32'h01);
        wr(8'h24, 32'h01);
        rd(8'h1C, v); chk("R8", "fire beats clear", v, 32'h01);
        rd(8'h28, v); chk("R8", "arm consumed in collision", v, 32'h00);
        wr(8'h24, 32'h01);
        rd(8'h1C, v); chk("R8", "plain clear afterwards", v, 32'h00);

        // R6: not in use blocks firing and keeps arm
        wr(8'h04, 32'h06);
        wr(8'h28, 32'h01);
        idle(3);
        rd(8'h1C, v); chk("R6", "not in use no fire", v, 32'h00);
        rd(8'h28, v); chk("R6", "arm kept when not in use", v, 32'h01);

        // R6: level mismatch on ch1 (filtered 0, polarity high)
        wr(8'h28, 32'h03);
        idle(3);
        rd(8'h1C, v); chk("R6", "mismatch no fire", v, 32'h00);
        rd(8'h28, v); chk("R6", "arm kept on mismatch", v, 32'h03);

        // R10: dropping enable of ch1 disarms only ch1
        wr(8'h18, 32'h00);
        rd(8'h28, v); chk("R10", "disable disarms", v, 32'h01);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule